// File: doc/BRIEF.md
# Scratchpad Address and Status Tracker

This block holds the 64-byte staging buffer that sits in front of a non-volatile memory array. A write command supplies a 16-bit target address, low byte first, followed by data bytes. The block stores the data from the byte offset given by the low six address bits and stops at the top of the buffer. It keeps a combined status byte that records the offset of the last full byte written, a flag for invalid contents, and a flag that a copy has completed. The block also adjusts the captured address: it drops bit 15 of an address beyond the user range, and it aligns targets in the password window to eight bytes.

A read-back command returns the stored address low byte, the high byte, the status byte and then the buffered data. A copy command must repeat the address and status bytes exactly. The block then raises a one-cycle grant or a one-cycle refusal. The external copy engine reads the buffer through a separate combinational port and reports completion. The serial link, the array and the password checks are outside the block, which sees only byte strobes, a count of leftover bits at the end of a write, and a power-loss pulse.

Top module: `sp_tracker`

## Requirements
- R1: After reset the address register is 0000h, the buffer holds 00h in every byte, and the status byte is 40h (invalid flag set, copy-done flag clear, ending offset 0).
- R2: Data bytes of a write are stored from offset TA[5:0] upward. The status bits 5:0 hold the offset of the last byte stored, and bytes that arrive after offset 3Fh has been written are dropped.
- R3: When a write closes with a nonzero leftover bit count, or closes without any full data byte, status bit 6 (invalid) is set.
- R4: A write that closes with a zero leftover count and at least one stored byte clears status bit 6. Every write start clears status bit 7 (copy done).
- R5: A copy-done pulse sets status bit 7, and a power-loss pulse sets status bit 6.
- R6: An address with bit 15 set is captured with bit 15 cleared, and the read-back shows the modified value.
- R7: A captured address in 7FC0h–7FCFh has bits 2:0 forced to 0. A write there that stores a byte count that is not a nonzero multiple of 8 sets status bit 6.
- R8: Each read request returns, one cycle later with a valid strobe, the next item of the sequence TA low, TA high, status, then data from offset TA[5:0] onward. Data positions past offset 3Fh return FFh. A read-start pulse restarts the sequence.
- R9: After a copy start, the third following byte strobe produces a one-cycle grant only if the three bytes equal TA low, TA high and status, in that order, and status bit 6 is clear. Otherwise it produces a one-cycle refusal. Grant and refusal never occur together.
- R10: Byte strobes that arrive outside a write or a copy change neither the buffer nor the address nor the status.
- R11: The copy read port returns the stored byte at the given offset in the same cycle, and the address output shows the captured target address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Start of a write command |
| wr_end | input | 1 | End of the write command |
| bit_rem | input | 3 | Leftover bits of an incomplete last byte, valid with wr_end |
| cp_start | input | 1 | Start of a copy command |
| byte_vld | input | 1 | Received byte strobe |
| byte_in | input | 8 | Received byte |
| rd_start | input | 1 | Restart the read-back sequence |
| rd_req | input | 1 | Request the next read-back byte |
| rd_data | output | 8 | Read-back byte |
| rd_vld | output | 1 | rd_data valid |
| cp_ok | output | 1 | Copy granted (one cycle) |
| cp_bad | output | 1 | Copy refused (one cycle) |
| copy_done | input | 1 | Copy completed by the array side |
| pwr_loss | input | 1 | Power-loss event |
| cp_raddr | input | 6 | Copy-side buffer offset |
| cp_rdata | output | 8 | Buffer byte at cp_raddr |
| ta_out | output | 16 | Captured target address |

## Verification
The hardest state to reach from the ports is a copy attempt that carries the correct address and status bytes while the invalid flag is set. It arises only after a partial, empty or misaligned password write, or after a power-loss pulse that lands after a good write. The bench builds that state on purpose and echoes the status byte it read back. It also runs seeded random writes whose addresses are biased toward the password window and the top half of the address space. Lengths run past the buffer end, and some writes end with leftover bits, so truncation, address forcing and the read-back FFh fill all occur together.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int SP_OFF_W  = 6;
    localparam int SP_DEPTH  = 1 << SP_OFF_W;
    localparam int SP_ADDR_W = 16;

    typedef struct packed {
        logic                aa;
        logic                pf;
        logic [SP_OFF_W-1:0] eoff;
    } es_t;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_WRITE = 2'd1,
        M_COPY  = 2'd2
    } mode_t;

    typedef enum logic [1:0] {
        PH_LO   = 2'd0,
        PH_HI   = 2'd1,
        PH_DATA = 2'd2
    } wphase_t;

    function automatic logic in_pwd_window(input logic [SP_ADDR_W-1:0] a);
        return a[15:4] == 12'h7FC;
    endfunction

    function automatic logic [SP_ADDR_W-1:0] fix_target(input logic [SP_ADDR_W-1:0] raw);
        logic [SP_ADDR_W-1:0] a;
        a = raw;
        a[15] = 1'b0;
        if (in_pwd_window(a)) a[2:0] = 3'b000;
        return a;
    endfunction
endpackage

// File: rtl/sp_store.sv
module sp_store
    import sp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SP_OFF_W-1:0] waddr,
    input  logic [7:0]          wdata,
    input  logic [SP_OFF_W-1:0] raddr_a,
    output logic [7:0]          rdata_a,
    input  logic [SP_OFF_W-1:0] raddr_b,
    output logic [7:0]          rdata_b
);
    logic [7:0] mem [SP_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SP_DEPTH; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sp_status.sv
module sp_status
    import sp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_start,
    input  logic                wr_close,
    input  logic [2:0]          bit_rem,
    input  logic [SP_OFF_W:0]   data_cnt,
    input  logic [SP_OFF_W-1:0] last_off,
    input  logic [SP_OFF_W-1:0] ta_off,
    input  logic                pwd_tgt,
    input  logic                pwr_loss,
    input  logic                copy_done,
    output es_t                 es
);
    logic write_bad;

    always_comb begin
        write_bad = (bit_rem != 3'd0) || (data_cnt == '0) ||
                    (pwd_tgt && (data_cnt[2:0] != 3'd0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            es <= '{aa: 1'b0, pf: 1'b1, eoff: '0};
        end else begin
            if (wr_start)       es.aa <= 1'b0;
            else if (copy_done) es.aa <= 1'b1;
            if (wr_close) begin
                es.pf   <= write_bad;
                es.eoff <= (data_cnt != '0) ? last_off : ta_off;
            end
            if (pwr_loss) es.pf <= 1'b1;
        end
    end

    p_pwr_sets_pf_r5: assert property (@(posedge clk) disable iff (rst)
        pwr_loss |=> es.pf);
    p_start_clears_aa_r4: assert property (@(posedge clk) disable iff (rst)
        wr_start |=> !es.aa);
    p_partial_sets_pf_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_close && bit_rem != 3'd0) |=> es.pf);
    p_pwd_group_pf_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_close && pwd_tgt && data_cnt[2:0] != 3'd0) |=> es.pf);
endmodule

// File: rtl/sp_readback.sv
module sp_readback
    import sp_pkg::*;
#(
    parameter int IDX_W = 8
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rd_start,
    input  logic                 rd_req,
    input  logic [SP_ADDR_W-1:0] ta,
    input  es_t                  es,
    output logic [SP_OFF_W-1:0]  mem_raddr,
    input  logic [7:0]           mem_rdata,
    output logic [7:0]           rd_data,
    output logic                 rd_vld
);
    localparam int HDR = 3;
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] idx;
    logic [IDX_W:0]   off_sum;
    logic [7:0]       item;

    always_comb begin
        off_sum   = {{(IDX_W+1-SP_OFF_W){1'b0}}, ta[SP_OFF_W-1:0]} +
                    {1'b0, idx} - (IDX_W+1)'(HDR);
        mem_raddr = off_sum[SP_OFF_W-1:0];
        case (idx)
            IDX_W'(0): item = ta[7:0];
            IDX_W'(1): item = ta[15:8];
            IDX_W'(2): item = es;
            default:   item = (off_sum >= (IDX_W+1)'(SP_DEPTH)) ? 8'hFF : mem_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx     <= '0;
            rd_data <= 8'h00;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= rd_req;
            if (rd_start) begin
                idx <= '0;
            end else if (rd_req) begin
                rd_data <= item;
                if (idx != IDX_MAX) idx <= idx + 1'b1;
            end
        end
    end

    p_rd_vld_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_start) |=> rd_vld);
endmodule

// File: rtl/sp_tracker.sv
module sp_tracker
    import sp_pkg::*;
#(
    parameter int RD_IDX_W = 8
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_start,
    input  logic                 wr_end,
    input  logic [2:0]           bit_rem,
    input  logic                 cp_start,
    input  logic                 byte_vld,
    input  logic [7:0]           byte_in,
    input  logic                 rd_start,
    input  logic                 rd_req,
    output logic [7:0]           rd_data,
    output logic                 rd_vld,
    output logic                 cp_ok,
    output logic                 cp_bad,
    input  logic                 copy_done,
    input  logic                 pwr_loss,
    input  logic [SP_OFF_W-1:0]  cp_raddr,
    output logic [7:0]           cp_rdata,
    output logic [SP_ADDR_W-1:0] ta_out
);
    mode_t                mode;
    wphase_t              phase;
    logic [7:0]           ta_lo_raw;
    logic [SP_ADDR_W-1:0] ta_q;
    logic [SP_OFF_W-1:0]  wr_ptr;
    logic [SP_OFF_W-1:0]  last_off;
    logic [SP_OFF_W:0]    data_cnt;
    logic                 full;
    logic                 pwd_tgt;
    logic [1:0]           cp_idx;
    logic                 cp_match;
    es_t                  es;

    logic                 mem_we;
    logic                 wr_close;
    logic [SP_OFF_W-1:0]  rb_raddr;
    logic [7:0]           rb_rdata;
    logic [7:0]           cp_expect;
    logic                 cp_hit;

    always_comb begin
        mem_we   = (mode == M_WRITE) && byte_vld && (phase == PH_DATA) && !full &&
                   !wr_start && !cp_start;
        wr_close = (mode == M_WRITE) && wr_end && !wr_start && !cp_start;
        case (cp_idx)
            2'd0:    cp_expect = ta_q[7:0];
            2'd1:    cp_expect = ta_q[15:8];
            default: cp_expect = es;
        endcase
        cp_hit = cp_match && (byte_in == cp_expect);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= M_IDLE;
            phase     <= PH_LO;
            ta_lo_raw <= 8'h00;
            ta_q      <= '0;
            wr_ptr    <= '0;
            last_off  <= '0;
            data_cnt  <= '0;
            full      <= 1'b0;
            pwd_tgt   <= 1'b0;
            cp_idx    <= 2'd0;
            cp_match  <= 1'b0;
            cp_ok     <= 1'b0;
            cp_bad    <= 1'b0;
        end else begin
            cp_ok  <= 1'b0;
            cp_bad <= 1'b0;
            if (wr_start) begin
                mode     <= M_WRITE;
                phase    <= PH_LO;
                data_cnt <= '0;
                full     <= 1'b0;
            end else if (cp_start) begin
                mode     <= M_COPY;
                cp_idx   <= 2'd0;
                cp_match <= 1'b1;
            end else begin
                case (mode)
                    M_WRITE: begin
                        if (wr_end) begin
                            mode <= M_IDLE;
                        end else if (byte_vld) begin
                            case (phase)
                                PH_LO: begin
                                    ta_lo_raw <= byte_in;
                                    phase     <= PH_HI;
                                end
                                PH_HI: begin
                                    ta_q    <= fix_target({byte_in, ta_lo_raw});
                                    wr_ptr  <= fix_target({byte_in, ta_lo_raw})
                                               [SP_OFF_W-1:0];
                                    pwd_tgt <= in_pwd_window(fix_target({byte_in, ta_lo_raw}));
                                    phase   <= PH_DATA;
                                end
                                default: begin
                                    if (!full) begin
                                        last_off <= wr_ptr;
                                        data_cnt <= data_cnt + 1'b1;
                                        if (wr_ptr == '1) full <= 1'b1;
                                        else              wr_ptr <= wr_ptr + 1'b1;
                                    end
                                end
                            endcase
                        end
                    end
                    M_COPY: begin
                        if (byte_vld) begin
                            if (cp_idx == 2'd2) begin
                                cp_ok  <= cp_hit && !es.pf;
                                cp_bad <= !(cp_hit && !es.pf);
                                mode   <= M_IDLE;
                            end else begin
                                cp_idx   <= cp_idx + 1'b1;
                                cp_match <= cp_hit;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    sp_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (mem_we),
        .waddr   (wr_ptr),
        .wdata   (byte_in),
        .raddr_a (rb_raddr),
        .rdata_a (rb_rdata),
        .raddr_b (cp_raddr),
        .rdata_b (cp_rdata)
    );

    sp_status u_status (
        .clk       (clk),
        .rst       (rst),
        .wr_start  (wr_start),
        .wr_close  (wr_close),
        .bit_rem   (bit_rem),
        .data_cnt  (data_cnt),
        .last_off  (last_off),
        .ta_off    (ta_q[SP_OFF_W-1:0]),
        .pwd_tgt   (pwd_tgt),
        .pwr_loss  (pwr_loss),
        .copy_done (copy_done),
        .es        (es)
    );

    sp_readback #(.IDX_W(RD_IDX_W)) u_readback (
        .clk       (clk),
        .rst       (rst),
        .rd_start  (rd_start),
        .rd_req    (rd_req),
        .ta        (ta_q),
        .es        (es),
        .mem_raddr (rb_raddr),
        .mem_rdata (rb_rdata),
        .rd_data   (rd_data),
        .rd_vld    (rd_vld)
    );

    assign ta_out = ta_q;

    p_grant_refuse_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(cp_ok && cp_bad));
    p_grant_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        cp_ok |-> $past(!es.pf));
    p_msb_cleared_r6: assert property (@(posedge clk) disable iff (rst)
        !ta_out[15]);
    p_pwd_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        (ta_out[15:4] == 12'h7FC) |-> (ta_out[2:0] == 3'b000));
    p_full_no_write_r2: assert property (@(posedge clk) disable iff (rst)
        (full && mode == M_WRITE) |-> !mem_we);
    p_idle_no_write_r10: assert property (@(posedge clk) disable iff (rst)
        (mode == M_IDLE && byte_vld) |-> !mem_we);
endmodule

// File: tb/sp_tracker_bench.sv
module sp_tracker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_start = 0, wr_end = 0, cp_start = 0, byte_vld = 0;
    logic [2:0]  bit_rem = 0;
    logic [7:0]  byte_in = 0;
    logic        rd_start = 0, rd_req = 0, copy_done = 0, pwr_loss = 0;
    logic [5:0]  cp_raddr = 0;
    logic [7:0]  rd_data, cp_rdata;
    logic        rd_vld, cp_ok, cp_bad;
    logic [15:0] ta_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0]  m_mem [64];
    logic [15:0] m_ta;
    logic [7:0]  m_es;

    always #4 clk = ~clk;

    sp_tracker u_sp_tracker (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_end(wr_end), .bit_rem(bit_rem),
        .cp_start(cp_start), .byte_vld(byte_vld), .byte_in(byte_in),
        .rd_start(rd_start), .rd_req(rd_req), .rd_data(rd_data), .rd_vld(rd_vld),
        .cp_ok(cp_ok), .cp_bad(cp_bad), .copy_done(copy_done), .pwr_loss(pwr_loss),
        .cp_raddr(cp_raddr), .cp_rdata(cp_rdata), .ta_out(ta_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_fix(input logic [15:0] a);
        logic [15:0] r;
        r = a;
        if (r >= 16'h8000) r = r - 16'h8000;
        if (r >= 16'h7FC0 && r <= 16'h7FCF) r = {r[15:3], 3'b000};
        return r;
    endfunction

    task automatic pulse_byte(input logic [7:0] b);
        @(negedge clk); byte_vld = 1; byte_in = b;
        @(negedge clk); byte_vld = 0;
    endtask

    task automatic do_write(input logic [15:0] addr, input int n, input logic [2:0] rem,
                            input int seed_base);
        logic [15:0] t;
        int ptr, cnt, last;
        bit full, pwd;
        logic [7:0] b;
        @(negedge clk); wr_start = 1;
        @(negedge clk); wr_start = 0;
        pulse_byte(addr[7:0]);
        pulse_byte(addr[15:8]);
        t = model_fix(addr);
        pwd = (t >= 16'h7FC0 && t <= 16'h7FCF);
        ptr = int'(t[5:0]); cnt = 0; last = 0; full = 0;
        for (int i = 0; i < n; i++) begin
            b = 8'((seed_base * 37 + i * 11 + 5) & 255);
            pulse_byte(b);
            if (!full) begin
                m_mem[ptr] = b; last = ptr; cnt++;
                if (ptr == 63) full = 1; else ptr++;
            end
        end
        @(negedge clk); wr_end = 1; bit_rem = rem;
        @(negedge clk); wr_end = 0; bit_rem = 0;
        m_ta = t;
        m_es[7] = 1'b0;
        m_es[6] = (rem != 0) || (cnt == 0) || (pwd && (cnt % 8) != 0);
        m_es[5:0] = (cnt != 0) ? 6'(last) : t[5:0];
    endtask

    task automatic read_one(output logic [7:0] v, output logic vl);
        @(negedge clk); rd_req = 1;
        @(negedge clk); rd_req = 0; v = rd_data; vl = rd_vld;
    endtask

    task automatic check_readback(input string tag);
        logic [7:0] v;
        logic vl;
        int off;
        @(negedge clk); rd_start = 1;
        @(negedge clk); rd_start = 0;
        read_one(v, vl); check({tag, " R8 vld"}, vl, 1); check({tag, " R8/R6 ta lo"}, v, m_ta[7:0]);
        read_one(v, vl); check({tag, " R8/R6 ta hi"}, v, m_ta[15:8]);
        read_one(v, vl); check({tag, " R8 status"}, v, m_es);
        off = int'(m_ta[5:0]);
        for (int k = 0; k < 66 - off; k++) begin
            read_one(v, vl);
            if (off + k < 64) check({tag, " R2/R8 data"}, v, m_mem[off + k]);
            else              check({tag, " R8 past end FF"}, v, 8'hFF);
        end
    endtask

    task automatic do_copy(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                           output logic ok, output logic bad);
        @(negedge clk); cp_start = 1;
        @(negedge clk); cp_start = 0;
        pulse_byte(b0); pulse_byte(b1);
        @(negedge clk); byte_vld = 1; byte_in = b2;
        @(negedge clk); byte_vld = 0; ok = cp_ok; bad = cp_bad;
        @(negedge clk);
        check("R9 one-cycle grant", cp_ok, 0);
    endtask

    task automatic pulse_copy_done();
        @(negedge clk); copy_done = 1;
        @(negedge clk); copy_done = 0;
        m_es[7] = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ok, bad;
        logic [15:0] a;
        int n, r;
        logic [2:0] rem;
        void'($urandom(32'd7341));
        for (int i = 0; i < 64; i++) m_mem[i] = 8'h00;
        m_ta = 16'h0000; m_es = 8'h40;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 ta reset", ta_out, 16'h0000);
        check_readback("R1 reset");

        do_write(16'h103C, 6, 3'd0, 1);
        check("R2 end offset 3F", m_es, 8'h3F);
        check_readback("R2 tail");

        do_write(16'h9234, 3, 3'd0, 2);
        check("R6 ta_out msb cleared", ta_out, 16'h1234);
        check_readback("R6");

        do_write(16'h7FC5, 8, 3'd0, 3);
        check("R7 ta_out aligned", ta_out, 16'h7FC0);
        check_readback("R7 full group");
        do_write(16'hFFCB, 5, 3'd0, 4);
        check("R7 pwd forced", ta_out, 16'h7FC8);
        check_readback("R7 short group");

        do_write(16'h0200, 4, 3'd3, 5);
        check_readback("R3 partial");
        do_write(16'h0210, 0, 3'd0, 6);
        check_readback("R3 empty");

        do_write(16'h0300, 10, 3'd0, 7);
        check_readback("R4 valid");
        do_copy(m_ta[7:0], m_ta[15:8], m_es, ok, bad);
        check("R9 grant", ok, 1); check("R9 no refusal", bad, 0);
        pulse_copy_done();
        check_readback("R5 copy done");
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cp_raddr = 6'(i * 3);
            #1 check("R11 copy read port", cp_rdata, m_mem[i * 3]);
        end
        do_copy(m_ta[7:0], m_ta[15:8] ^ 8'h01, m_es, ok, bad);
        check("R9 mismatch refused", bad, 1); check("R9 mismatch no grant", ok, 0);

        @(negedge clk); pwr_loss = 1;
        @(negedge clk); pwr_loss = 0;
        m_es[6] = 1'b1;
        check_readback("R5 power loss");
        do_copy(m_ta[7:0], m_ta[15:8], m_es, ok, bad);
        check("R9 invalid refused", bad, 1); check("R9 invalid no grant", ok, 0);

        do_write(16'h0400, 2, 3'd0, 8);
        check("R4 start clears aa", m_es[7], 0);
        pulse_byte(8'h5A); pulse_byte(8'hA5);
        check_readback("R10 idle bytes");

        for (int it = 0; it < 25; it++) begin
            r = int'($urandom % 4);
            a = 16'($urandom);
            if (r == 0) a = {($urandom % 2) ? 1'b1 : 1'b0, 11'h7FC >> 0 == 0 ? 11'h0 : 11'h3FE, 4'($urandom)};
            if (r == 0) a = {1'($urandom), 15'h7FC0 + 15'($urandom % 16)};
            n = int'($urandom % 72);
            rem = ($urandom % 5 == 0) ? 3'(1 + $urandom % 7) : 3'd0;
            do_write(a, n, rem, 100 + it);
            check_readback("R2/R6/R7 random");
            do_copy(m_ta[7:0], m_ta[15:8], m_es, ok, bad);
            check("R9 random grant", ok, !m_es[6]);
            check("R9 random refusal", bad, m_es[6]);
            if (ok) begin
                pulse_copy_done();
                check_readback("R5 random aa");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule